// File: doc/BRIEF.md
# Widening Vector Multiply Element Selector

This unit multiplies pairs of narrow elements taken from two vector operands and writes the double-width products into a single destination vector of the same total width. Because each product is twice as wide as its inputs, only half of the source elements can be used in one operation. A 2-bit mode picks which half: the bottom half of the register, the top half, the even-numbered elements, or the odd-numbered elements. A sign control chooses whether the operands are treated as two's complement or unsigned numbers. Each product is exact.

The vector is built from physical lanes of `LANE` bits. When the bottom or top half is selected and the vector is wider than one lane, a product lands in a different lane from its sources. The even and odd selections never do this, because element pairs 2i and 2i+1 occupy the same bits as destination element i. The unit reports this property with each result so that the surrounding datapath can account for the extra routing. Results are registered, and a valid strobe follows the request by one clock.

Top module: `wvm_unit`

## Requirements
- R1: With mode 2'b00 (bottom half), destination element i is the product of source element i of `src_a` and of `src_b`, for i from 0 to VLEN/(2*EW)-1.
- R2: With mode 2'b01 (top half), destination element i is the product of source elements i + VLEN/(2*EW).
- R3: With mode 2'b10 (even), destination element i is the product of source elements 2i.
- R4: With mode 2'b11 (odd), destination element i is the product of source elements 2i+1.
- R5: Source element k occupies bits EW*k to EW*k+EW-1, and destination element i occupies bits 2*EW*i to 2*EW*i+2*EW-1. When `is_signed` is 1 the operands are sign-extended, and when it is 0 they are zero-extended. The 2*EW-bit product is exact.
- R6: `out_valid` is 1 exactly one clock after `in_valid` was 1. `dst` and `lane_cross` take the new result on that same edge.
- R7: While `in_valid` is 0, `dst` and `lane_cross` keep their previous values, whatever the other inputs do.
- R8: `lane_cross` is 1 for modes 2'b00 and 2'b01 when VLEN > LANE, and 0 for every other case.
- R9: A synchronous active-high `rst` clears `out_valid`, `dst` and `lane_cross` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Element selection: 00 bottom, 01 top, 10 even, 11 odd |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| src_a | input | VLEN | First source vector |
| src_b | input | VLEN | Second source vector |
| out_valid | output | 1 | Result valid, one clock after the request |
| dst | output | VLEN | Destination vector of double-width products |
| lane_cross | output | 1 | The selected mode moved data across physical lanes |

## Verification
Each source element in the stimulus carries a distinct value, so any selector that uses the wrong index, such as i instead of 2i or an off-by-half offset in top mode, produces a wrong product in some destination element. Operands of 0x8000 and 0xFFFF under both sign settings expose a multiplier that zero-extends when it should sign-extend, or the reverse, and also one that truncates the most negative square. Idle cycles with changing inputs reveal a register that loads without a request. Switching between the four modes checks that the lane-crossing flag follows the mode's high bit and does not stay fixed.

// File: rtl/wvm_pkg.sv
package wvm_pkg;

  typedef enum logic [1:0] {
    WM_LOW  = 2'b00,
    WM_HIGH = 2'b01,
    WM_EVEN = 2'b10,
    WM_ODD  = 2'b11
  } wmode_e;

  // Index of the source element feeding destination element i.
  function automatic int src_pos(wmode_e m, int i, int nout);
    case (m)
      WM_LOW:  return i;
      WM_HIGH: return i + nout;
      WM_EVEN: return 2 * i;
      default: return 2 * i + 1;
    endcase
  endfunction

  // Half-register modes move data across lanes once the vector spans lanes.
  function automatic logic mode_crosses(wmode_e m, int vlen, int lane);
    return (vlen > lane) && !m[1];
  endfunction

endpackage

// File: rtl/wvm_select.sv
module wvm_select
  import wvm_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int EW   = 16
) (
  input  wmode_e               mode,
  input  logic [VLEN-1:0]      src,
  output logic [VLEN/2-1:0]    pick
);
  localparam int NOUT = VLEN / (2 * EW);

  for (genvar i = 0; i < NOUT; i++) begin : g_elem
    localparam int P_LO = src_pos(WM_LOW,  i, NOUT);
    localparam int P_HI = src_pos(WM_HIGH, i, NOUT);
    localparam int P_EV = src_pos(WM_EVEN, i, NOUT);
    localparam int P_OD = src_pos(WM_ODD,  i, NOUT);
    always_comb begin
      unique case (mode)
        WM_LOW:  pick[i*EW +: EW] = src[P_LO*EW +: EW];
        WM_HIGH: pick[i*EW +: EW] = src[P_HI*EW +: EW];
        WM_EVEN: pick[i*EW +: EW] = src[P_EV*EW +: EW];
        WM_ODD:  pick[i*EW +: EW] = src[P_OD*EW +: EW];
      endcase
    end
  end

endmodule

// File: rtl/wvm_widen_mul.sv
module wvm_widen_mul #(
  parameter int EW = 16
) (
  input  logic [EW-1:0]   a,
  input  logic [EW-1:0]   b,
  input  logic            is_signed,
  output logic [2*EW-1:0] prod
);
  // Extend both operands to the product width, then multiply; the low
  // 2*EW bits of that product are the exact signed or unsigned result.
  function automatic logic [2*EW-1:0] widen_product(logic [EW-1:0] x,
                                                    logic [EW-1:0] y,
                                                    logic sgn);
    logic [2*EW-1:0] xe, ye;
    xe = {{EW{sgn & x[EW-1]}}, x};
    ye = {{EW{sgn & y[EW-1]}}, y};
    return xe * ye;
  endfunction

  assign prod = widen_product(a, b, is_signed);

endmodule

// File: rtl/wvm_unit.sv
module wvm_unit
  import wvm_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int LANE = 32,
  parameter int EW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      mode,
  input  logic            is_signed,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  output logic            out_valid,
  output logic [VLEN-1:0] dst,
  output logic            lane_cross
);
  localparam int NOUT = VLEN / (2 * EW);
  localparam int HALF = VLEN / 2;

  wmode_e            mode_e;
  logic [HALF-1:0]   pick_a;
  logic [HALF-1:0]   pick_b;
  logic [VLEN-1:0]   comb_dst;
  logic              comb_cross;
  logic              load_en;

  assign mode_e     = wmode_e'(mode);
  assign load_en    = in_valid;
  assign comb_cross = mode_crosses(mode_e, VLEN, LANE);

  wvm_select #(.VLEN(VLEN), .EW(EW)) u_sel_a (
    .mode(mode_e), .src(src_a), .pick(pick_a)
  );
  wvm_select #(.VLEN(VLEN), .EW(EW)) u_sel_b (
    .mode(mode_e), .src(src_b), .pick(pick_b)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_mul
    wvm_widen_mul #(.EW(EW)) u_mul (
      .a        (pick_a[i*EW +: EW]),
      .b        (pick_b[i*EW +: EW]),
      .is_signed(is_signed),
      .prod     (comb_dst[i*2*EW +: 2*EW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      dst        <= '0;
      lane_cross <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (load_en) begin
        dst        <= comb_dst;
        lane_cross <= comb_cross;
      end
    end
  end

endmodule

// File: rtl/wvm_unit_chk.sv
module wvm_unit_chk #(
  parameter int VLEN = 128,
  parameter int LANE = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      mode,
  input logic            out_valid,
  input logic [VLEN-1:0] dst,
  input logic            lane_cross
);
  localparam logic SPANS = (VLEN > LANE);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);                                   // R6
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);                                 // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dst) && $stable(lane_cross)));      // R7
  AST_CROSS_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (lane_cross == (SPANS && !$past(mode[1]))));  // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && dst == '0 && !lane_cross));         // R9

endmodule

bind wvm_unit wvm_unit_chk #(.VLEN(VLEN), .LANE(LANE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
  .out_valid(out_valid), .dst(dst), .lane_cross(lane_cross)
);

// File: tb/wvm_unit_tb_top.sv
module wvm_unit_tb_top;
  localparam int VLEN = 128;
  localparam int LANE = 32;
  localparam int EW   = 16;
  localparam int NOUT = VLEN / (2 * EW);
  localparam int NIN  = VLEN / EW;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [1:0]      mode;
  logic            is_signed;
  logic [VLEN-1:0] src_a;
  logic [VLEN-1:0] src_b;
  logic            out_valid;
  logic [VLEN-1:0] dst;
  logic            lane_cross;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wvm_unit #(.VLEN(VLEN), .LANE(LANE), .EW(EW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .is_signed(is_signed), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .dst(dst), .lane_cross(lane_cross)
  );

  // Reference: which source element feeds destination i, per mode code.
  function automatic int ref_index(logic [1:0] m, int i);
    if (m == 2'b00) return i;
    if (m == 2'b01) return NOUT + i;
    if (m == 2'b10) return i * 2;
    return i * 2 + 1;
  endfunction

  function automatic longint ref_val(logic [VLEN-1:0] v, int k, logic sgn);
    logic [EW-1:0] e;
    e = v[k*EW +: EW];
    if (sgn && e[EW-1]) return longint'(e) - (longint'(1) <<< EW);
    return longint'(e);
  endfunction

  function automatic logic [VLEN-1:0] ref_dst(logic [1:0] m, logic sgn,
                                              logic [VLEN-1:0] a,
                                              logic [VLEN-1:0] b);
    logic [VLEN-1:0] r;
    longint p;
    r = '0;
    for (int i = 0; i < NOUT; i++) begin
      p = ref_val(a, ref_index(m, i), sgn) * ref_val(b, ref_index(m, i), sgn);
      r[i*2*EW +: 2*EW] = p[2*EW-1:0];
    end
    return r;
  endfunction

  task automatic check(string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] ramp(int base, int step);
    logic [VLEN-1:0] v;
    for (int k = 0; k < NIN; k++) v[k*EW +: EW] = EW'(base + step * k);
    return v;
  endfunction

  // Issue one request at a falling edge, check the result one edge later.
  task automatic issue(string req, logic [1:0] m, logic sgn,
                       logic [VLEN-1:0] a, logic [VLEN-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; mode = m; is_signed = sgn; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " dst"}, dst, ref_dst(m, sgn, a, b));
    check({req, " out_valid R6"}, VLEN'(out_valid), VLEN'(1));
    check({req, " lane_cross R8"}, VLEN'(lane_cross),
          VLEN'((VLEN > LANE) && !m[1]));
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; mode = 2'b00; is_signed = 1'b0;
    src_a = '0; src_b = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9 out_valid", VLEN'(out_valid), '0);
    check("R9 dst", dst, '0);
    check("R9 lane_cross", VLEN'(lane_cross), '0);
  endtask

  task automatic t_modes();
    logic [VLEN-1:0] a, b;
    a = ramp(16'h0103, 16'h0111);
    b = ramp(16'h0007, 16'h0013);
    issue("R1 bottom", 2'b00, 1'b0, a, b);
    issue("R2 top",    2'b01, 1'b0, a, b);
    issue("R3 even",   2'b10, 1'b0, a, b);
    issue("R4 odd",    2'b11, 1'b0, a, b);
  endtask

  task automatic t_sign();
    logic [VLEN-1:0] a, b;
    a = ramp(16'h8000, 16'h3FFF);
    b = ramp(16'hFFFF, 16'h7001);
    issue("R5 signed even",  2'b10, 1'b1, a, b);
    issue("R5 unsigned odd", 2'b11, 1'b0, a, b);
    a = {NIN{16'h8000}};
    issue("R5 signed min square", 2'b00, 1'b1, a, a);
    a = {NIN{16'hFFFF}};
    issue("R5 unsigned max square", 2'b01, 1'b0, a, a);
  endtask

  task automatic t_hold();
    logic [VLEN-1:0] a, b, keep;
    a = ramp(16'h0021, 16'h0105);
    b = ramp(16'h0300, 16'h0011);
    issue("R7 prime", 2'b00, 1'b0, a, b);
    keep = ref_dst(2'b00, 1'b0, a, b);
    @(negedge clk);
    mode = 2'b10; is_signed = 1'b1; src_a = ~a; src_b = ~b;
    @(negedge clk);
    @(negedge clk);
    check("R7 dst held", dst, keep);
    check("R7 lane_cross held", VLEN'(lane_cross), VLEN'(1));
    check("R6 out_valid idle", VLEN'(out_valid), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_modes();
    t_sign();
    t_hold();
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule